// File: doc/BRIEF.md
# Root Port Error Collector and Interrupt

This block sits at a PCI Express root port and turns a stream of received error messages into root error status. Each message carries a severity (correctable, non-fatal or fatal) and a 16-bit requester identifier. The block records which severities have arrived and whether more than one arrived in a class. It separately tracks whether the first uncorrectable message was fatal. It also keeps the identifier of the first correctable and the first uncorrectable sender until software clears the matching status.

Software programs a three-bit enable register and clears status bits by writing ones. The block raises an interrupt when an enabled, received condition exists. With message-signalled interrupts disabled, it drives a level that follows that condition. With them enabled, it issues a one-cycle request only when the condition turns from false to true. The request carries the 5-bit message number that a side input places in the upper status bits.

Top module: `root_err_collector`

## Requirements
- R1: A correctable message (severity code 0) whose correctable-received flag (status bit 0) is clear stores its source ID in bits 15:0 of `src_ids` and sets bit 0. If bit 0 is already set, the message sets multiple-correctable (bit 1) and leaves the stored ID unchanged.
- R2: A non-fatal message (severity code 1) sets non-fatal-received (status bit 5).
- R3: A fatal message (severity code 2) sets fatal-received (bit 6). It also sets first-fatal (bit 4), but only if uncorrectable-received (bit 2) was clear before that message.
- R4: A non-fatal or fatal message whose uncorrectable-received bit 2 is clear stores its source ID in bits 31:16 of `src_ids` and sets bit 2. If bit 2 is already set, it sets multiple-uncorrectable (bit 3) and leaves the stored ID unchanged.
- R5: A message with severity code 3 changes no status, source ID or interrupt output.
- R6: A status write clears each of bits 6:0 whose write-data bit is 1. A message in the same cycle acts on the already-cleared status.
- R7: Status bits 31:27 show `msg_num_in` one cycle later, and status writes do not change them. `msi_num_o` presents the same field.
- R8: Reset clears the command register, status bits 6:0 and both source IDs, and drops both interrupt outputs.
- R9: With `msi_en` low, `intx_o` equals the OR of (command bit 0 AND status bit 0), (command bit 1 AND status bit 5) and (command bit 2 AND status bit 6). It takes that value in the same cycle as the status and command it reflects. With `msi_en` high, `intx_o` is low.
- R10: With `msi_en` high, `msi_req_o` is high for exactly one cycle when the R9 condition goes from false to true, whether a message or a command write causes it. No request is issued while the condition is already true.
- R11: A command write loads bit 0 as the correctable enable, bit 1 as the non-fatal enable and bit 2 as the fatal enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | An error message is present this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 ignored |
| msg_src | input | 16 | Requester ID of the message |
| cmd_we | input | 1 | Write strobe for the enable register |
| cmd_wdata | input | 3 | Enable value {fatal, non-fatal, correctable} |
| sts_we | input | 1 | Write-one-to-clear strobe for status |
| sts_wdata | input | 32 | Clear mask; only bits 6:0 act |
| msi_en | input | 1 | Selects message-signalled interrupts over the level output |
| msg_num_in | input | 5 | Interrupt message number placed in status bits 31:27 |
| root_cmd | output | 3 | Current enable register |
| root_sts | output | 32 | Root error status |
| src_ids | output | 32 | {first uncorrectable ID, first correctable ID} |
| intx_o | output | 1 | Level interrupt |
| msi_req_o | output | 1 | One-cycle message-signalled interrupt request |
| msi_num_o | output | 5 | Message number for the request |

## Verification
Message sequences are run in several orders. A correctable message followed by a second one separates first capture from the multiple flag. A non-fatal message arriving before a fatal one shows that first-fatal tracks the first uncorrectable message, not any fatal message. A fatal message on a cleared status shows the opposite case. The interrupt is exercised in two ways: enabling a severity after its status is already set, and sending a second message of an enabled severity. Together these show that a request is issued on the false-to-true change and not on every event. A clear in the same cycle as a message shows that the clear is applied first.

// File: rtl/root_err_collector.sv
module root_err_collector #(
  parameter int SRC_W = 16,
  parameter int NUM_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_valid,
  input  logic [1:0]         msg_sev,
  input  logic [SRC_W-1:0]   msg_src,
  input  logic               cmd_we,
  input  logic [2:0]         cmd_wdata,
  input  logic               sts_we,
  input  logic [31:0]        sts_wdata,
  input  logic               msi_en,
  input  logic [NUM_W-1:0]   msg_num_in,
  output logic [2:0]         root_cmd,
  output logic [31:0]        root_sts,
  output logic [2*SRC_W-1:0] src_ids,
  output logic               intx_o,
  output logic               msi_req_o,
  output logic [NUM_W-1:0]   msi_num_o
);

  localparam int B_COR  = 0;
  localparam int B_MCOR = 1;
  localparam int B_UNC  = 2;
  localparam int B_MUNC = 3;
  localparam int B_FF   = 4;
  localparam int B_NF   = 5;
  localparam int B_FAT  = 6;
  localparam int FLAG_W = 7;
  localparam int PAD_W  = 32 - NUM_W - FLAG_W;

  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [2:0]        cmd_q, cmd_d;
  logic [SRC_W-1:0]  src_cor_q, src_unc_q;
  logic [NUM_W-1:0]  num_q;
  logic              intx_q, msi_q;
  logic              cap_cor, cap_unc;
  logic              cond_cur, cond_nxt;

  wire is_cor = msg_valid && (msg_sev == 2'd0);
  wire is_nf  = msg_valid && (msg_sev == 2'd1);
  wire is_fat = msg_valid && (msg_sev == 2'd2);

  function automatic logic [2:0] rcv_map(input logic [FLAG_W-1:0] f);
    return {f[B_FAT], f[B_NF], f[B_COR]};
  endfunction

  always_comb begin
    flags_d = flags_q;
    cap_cor = 1'b0;
    cap_unc = 1'b0;
    if (sts_we) flags_d = flags_d & ~sts_wdata[FLAG_W-1:0];
    if (is_cor) begin
      if (flags_d[B_COR]) flags_d[B_MCOR] = 1'b1;
      else                cap_cor = 1'b1;
      flags_d[B_COR] = 1'b1;
    end
    if (is_nf) flags_d[B_NF] = 1'b1;
    if (is_fat) begin
      if (!flags_d[B_UNC]) flags_d[B_FF] = 1'b1;
      flags_d[B_FAT] = 1'b1;
    end
    if (is_nf || is_fat) begin
      if (flags_d[B_UNC]) flags_d[B_MUNC] = 1'b1;
      else                cap_unc = 1'b1;
      flags_d[B_UNC] = 1'b1;
    end
  end

  assign cmd_d    = cmd_we ? cmd_wdata : cmd_q;
  assign cond_cur = |(cmd_q & rcv_map(flags_q));
  assign cond_nxt = |(cmd_d & rcv_map(flags_d));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q   <= '0;
      cmd_q     <= '0;
      src_cor_q <= '0;
      src_unc_q <= '0;
      num_q     <= '0;
      intx_q    <= 1'b0;
      msi_q     <= 1'b0;
    end else begin
      flags_q <= flags_d;
      cmd_q   <= cmd_d;
      num_q   <= msg_num_in;
      if (cap_cor) src_cor_q <= msg_src;
      if (cap_unc) src_unc_q <= msg_src;
      intx_q  <= !msi_en && cond_nxt;
      msi_q   <= msi_en && cond_nxt && !cond_cur;
    end
  end

  assign root_cmd  = cmd_q;
  assign root_sts  = {num_q, {PAD_W{1'b0}}, flags_q};
  assign src_ids   = {src_unc_q, src_cor_q};
  assign intx_o    = intx_q;
  assign msi_req_o = msi_q;
  assign msi_num_o = num_q;

  assert_cor_first_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cor && !sts_we && !flags_q[B_COR]) |=>
      (src_ids[SRC_W-1:0] == $past(msg_src)) && root_sts[B_COR]);

  assert_cor_multi_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cor && !sts_we && flags_q[B_COR]) |=>
      root_sts[B_MCOR] && $stable(src_ids[SRC_W-1:0]));

  assert_first_fatal_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fat && !sts_we && flags_q[B_UNC]) |=>
      (root_sts[B_FF] == $past(flags_q[B_FF])) && root_sts[B_FAT]);

  assert_unc_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_nf || is_fat) && !sts_we && !flags_q[B_UNC]) |=>
      (src_ids[2*SRC_W-1:SRC_W] == $past(msg_src)));

  assert_msi_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req_o |=> !msi_req_o);

  assert_no_level_with_msi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(msi_en) |-> !intx_o);

  assert_num_readonly_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_we |=> (root_sts[31 -: NUM_W] == $past(msg_num_in)));

endmodule

// File: tb/tb_root_err_collector.sv
module tb_root_err_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [1:0]  msg_sev = '0;
  logic [15:0] msg_src = '0;
  logic        cmd_we = 1'b0;
  logic [2:0]  cmd_wdata = '0;
  logic        sts_we = 1'b0;
  logic [31:0] sts_wdata = '0;
  logic        msi_en = 1'b0;
  logic [4:0]  msg_num_in = 5'd9;
  logic [2:0]  root_cmd;
  logic [31:0] root_sts;
  logic [31:0] src_ids;
  logic        intx_o, msi_req_o;
  logic [4:0]  msi_num_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  root_err_collector dut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
    .msg_src(msg_src), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .msi_en(msi_en),
    .msg_num_in(msg_num_in), .root_cmd(root_cmd), .root_sts(root_sts),
    .src_ids(src_ids), .intx_o(intx_o), .msi_req_o(msi_req_o),
    .msi_num_o(msi_num_o)
  );

  // row: op[61:60] 0 msg 1 cmd 2 clear, sev[59:58], data[57:42], msien[41],
  //      status[40:34], src[33:2], intx[1], msi[0]
  localparam int NV = 18;
  localparam logic [61:0] TBL [NV] = '{
    {2'd1, 2'd0, 16'h0001, 1'b0, 7'h00, 32'h00000000, 1'b0, 1'b0},
    {2'd0, 2'd0, 16'h1111, 1'b0, 7'h01, 32'h00001111, 1'b1, 1'b0},
    {2'd0, 2'd0, 16'h2222, 1'b0, 7'h03, 32'h00001111, 1'b1, 1'b0},
    {2'd0, 2'd1, 16'h3333, 1'b0, 7'h27, 32'h33331111, 1'b1, 1'b0},
    {2'd0, 2'd2, 16'h4444, 1'b0, 7'h6F, 32'h33331111, 1'b1, 1'b0},
    {2'd2, 2'd0, 16'h007F, 1'b0, 7'h00, 32'h33331111, 1'b0, 1'b0},
    {2'd0, 2'd3, 16'h5555, 1'b0, 7'h00, 32'h33331111, 1'b0, 1'b0},
    {2'd0, 2'd2, 16'h6666, 1'b0, 7'h54, 32'h66661111, 1'b0, 1'b0},
    {2'd1, 2'd0, 16'h0004, 1'b0, 7'h54, 32'h66661111, 1'b1, 1'b0},
    {2'd2, 2'd0, 16'h0054, 1'b0, 7'h00, 32'h66661111, 1'b0, 1'b0},
    {2'd1, 2'd0, 16'h0002, 1'b1, 7'h00, 32'h66661111, 1'b0, 1'b0},
    {2'd0, 2'd1, 16'h7777, 1'b1, 7'h24, 32'h77771111, 1'b0, 1'b1},
    {2'd0, 2'd1, 16'h8888, 1'b1, 7'h2C, 32'h77771111, 1'b0, 1'b0},
    {2'd1, 2'd0, 16'h0000, 1'b1, 7'h2C, 32'h77771111, 1'b0, 1'b0},
    {2'd1, 2'd0, 16'h0002, 1'b1, 7'h2C, 32'h77771111, 1'b0, 1'b1},
    {2'd0, 2'd0, 16'h9999, 1'b1, 7'h2D, 32'h77779999, 1'b0, 1'b0},
    {2'd2, 2'd0, 16'h007F, 1'b1, 7'h00, 32'h77779999, 1'b0, 1'b0},
    {2'd0, 2'd0, 16'hAAAA, 1'b1, 7'h01, 32'h7777AAAA, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string row_tag(input logic [1:0] op, input logic [1:0] sev);
    if (op == 2'd1) return "R11";
    if (op == 2'd2) return "R6";
    case (sev)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic do_op(input logic [1:0] op, input logic [1:0] sev,
                       input logic [15:0] data, input logic men);
    @(negedge clk);
    msi_en = men;
    msg_valid = (op == 2'd0);
    msg_sev = sev;
    msg_src = data;
    cmd_we = (op == 2'd1);
    cmd_wdata = data[2:0];
    sts_we = (op == 2'd2);
    sts_wdata = {16'h0, data};
    @(negedge clk);
    msg_valid = 1'b0;
    cmd_we = 1'b0;
    sts_we = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset cmd", {29'd0, root_cmd}, 32'h0);
    check("R8 reset status", root_sts, 32'h0);
    check("R8 reset src", src_ids, 32'h0);
    check("R8 reset intx", {31'd0, intx_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 number field", {27'd0, root_sts[31:27]}, 32'd9);

    for (int i = 0; i < NV; i++) begin
      logic [61:0] v;
      string t;
      v = TBL[i];
      t = row_tag(v[61:60], v[59:58]);
      do_op(v[61:60], v[59:58], v[57:42], v[41]);
      check({t, " status"}, {25'd0, root_sts[6:0]}, {25'd0, v[40:34]});
      check((v[61:60] == 2'd0 && v[59:58] != 2'd0) ? "R4 src" : {t, " src"}, src_ids, v[33:2]);
      check("R9 intx", {31'd0, intx_o}, {31'd0, v[1]});
      check("R10 msi", {31'd0, msi_req_o}, {31'd0, v[0]});
      if (v[61:60] == 2'd1) check("R11 cmd", {29'd0, root_cmd}, {29'd0, v[44:42]});
    end

    // R6: clear and message in the same cycle; the clear acts first
    @(negedge clk);
    sts_we = 1'b1; sts_wdata = 32'h1;
    msg_valid = 1'b1; msg_sev = 2'd0; msg_src = 16'hBBBB;
    @(negedge clk);
    sts_we = 1'b0; msg_valid = 1'b0;
    check("R6 same-cycle status", {25'd0, root_sts[6:0]}, 32'h01);
    check("R6 same-cycle src", src_ids, 32'h7777BBBB);

    // R7: writes cannot touch the number field; it follows the side input
    do_op(2'd2, 2'd0, 16'hFFFF, 1'b1);
    @(negedge clk);
    sts_we = 1'b1; sts_wdata = 32'hFFFFFFFF;
    @(negedge clk);
    sts_we = 1'b0;
    check("R7 field after write", {27'd0, root_sts[31:27]}, 32'd9);
    msg_num_in = 5'd21;
    @(negedge clk);
    check("R7 field follows input", {27'd0, root_sts[31:27]}, 32'd21);
    check("R7 msi number", {27'd0, msi_num_o}, 32'd21);

    // R10: request carries the new number
    do_op(2'd0, 2'd1, 16'hCCCC, 1'b1);
    check("R10 msi request", {31'd0, msi_req_o}, 32'h1);
    check("R10 msi number", {27'd0, msi_num_o}, 32'd21);
    @(negedge clk);
    check("R10 msi one cycle", {31'd0, msi_req_o}, 32'h0);

    // R9: level mode on an already-true condition
    do_op(2'd1, 2'd0, 16'h0002, 1'b0);
    check("R9 level asserted", {31'd0, intx_o}, 32'h1);
    check("R9 no msi in level mode", {31'd0, msi_req_o}, 32'h0);

    // R8: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 mid reset cmd", {29'd0, root_cmd}, 32'h0);
    check("R8 mid reset status", {25'd0, root_sts[6:0]}, 32'h0);
    check("R8 mid reset src", src_ids, 32'h0);
    check("R8 mid reset intx", {31'd0, intx_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule